// File: doc/BRIEF.md
# Single-Precision to 4-bit E2M1 Quantizer

This block turns a stream of 32-bit single-precision values into 4-bit floating-point codes with one sign bit, two exponent bits and one mantissa bit. The output grid has only eight magnitudes and no infinity or NaN codes. Anything too large saturates to the largest finite code. Each input carries its own rounding-mode sideband bit. The two modes are round-to-nearest with ties to the even mantissa, and stochastic rounding driven by an internal 16-bit linear-feedback shift register.

Data moves on a valid/ready stream at both ends. An input is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. An output is taken on a rising edge when `out_valid` and `out_ready` are both high. The pipeline is either one or two stages deep, chosen by a parameter, and all stages advance together. While the output holds an untaken result, the whole pipeline stalls and `in_ready` stays low. Reset is synchronous and active low. The package also provides a helper function that expands a 4-bit code back to single precision.

Top module: `fp4_quantizer`

## Requirements
- R1: The output code is {sign, exp[1:0], man}, and it decodes to (-1)^sign * 2^(exp-1) * (1+man/2) when exp is nonzero, or to (-1)^sign * man/2 when exp is zero. An input equal to one of the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4 or 6 maps exactly to that code (for example 3.0 gives 4'h5 and -1.5 gives 4'hB).
- R2: When the mode bit is 0, the result is the nearest grid value. A value exactly halfway between two grid values goes to the code with man = 0 (0.25 gives 0, 0.75 gives 1.0, 1.75 gives 2.0, 2.5 gives 2.0, 3.5 gives 4.0, 5.0 gives 4.0).
- R3: Any non-NaN input whose magnitude rounds above 6, including infinities, gives {sign, 3'b111}.
- R4: Any NaN input, whatever its sign bit, gives 4'b0111.
- R5: The sign is kept for zero and for values that round to zero: +0 gives 4'h0 and -0 gives 4'h8.
- R6: When the mode bit is 1, exact grid values are unchanged. Any other value gives one of its two neighbouring grid values. It rounds up with probability equal to its distance above the lower neighbour divided by the gap, so 0.75 rounds up about half the time and 2.25 rounds up about a quarter of the time.
- R7: The random source is a 16-bit maximal-length LFSR. It loads `lfsr_seed` while reset is held, and a zero seed is replaced by 16'hACE1. It advances only on accepted inputs, so the same seed and the same accepted inputs give the same results whatever idle cycles fall between them.
- R8: With `out_ready` high, a result appears on `out_valid`/`out_code` LATENCY cycles after its input is accepted, and results leave in the order their inputs arrived.
- R9: While `out_valid` is high and `out_ready` is low, `out_code` holds steady and `in_ready` is low.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: The package function `fp4_decode` returns the exact single-precision encoding of each of the 16 codes, with -0 for 4'h8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lfsr_seed | input | 16 | Random-source seed, loaded while in reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_data | input | 32 | Single-precision input value |
| in_stoch | input | 1 | Rounding mode for this input: 0 nearest-even, 1 stochastic |
| out_valid | output | 1 | Output code present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_code | output | 4 | E2M1 result code |

## Verification
The bench targets every tie point on the uneven grid. A design that breaks ties upward or by magnitude parity would return 2.5 as 3 or 5.0 as 6. It drives 1.75 and 7.0 so that a rounding carry must move into the exponent: a missing carry gives a wrong code, and a missing saturation check gives a code that wraps. It also drives NaN, infinities, signed zero and the smallest subnormals, where a design that ignores the sign or treats NaN like infinity would be caught. For stochastic mode it measures the round-up rate at two fractional positions, replays a seeded sequence with idle gaps to catch a random source that advances on idle cycles, and holds the output stalled to catch a code that changes or data that is lost under back-pressure.

// File: rtl/fp4_pkg.sv
package fp4_pkg;

  localparam logic [3:0] FP4_POS_MAX = 4'b0111;

  typedef enum logic {
    RND_NEAREST = 1'b0,
    RND_STOCH   = 1'b1
  } fp4_rnd_e;

  // Expand a 4-bit E2M1 code into single precision.
  function automatic logic [31:0] fp4_decode(input logic [3:0] code);
    logic [7:0]  bexp;
    logic [22:0] bman;
    if (code[2:1] == 2'b00) begin
      bexp = code[0] ? 8'd126 : 8'd0;
      bman = '0;
    end else begin
      bexp = 8'd126 + {6'd0, code[2:1]};
      bman = {code[0], 22'd0};
    end
    return {code[3], bexp, bman};
  endfunction

endpackage

// File: rtl/fp4_lfsr.sv
module fp4_lfsr #(
  parameter int           W        = 16,
  parameter logic [W-1:0] TAPS     = 16'hB400,
  parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);

  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= (seed == '0) ? FALLBACK : seed;
    end else if (step) begin
      state <= {state[W-2:0], fb};
    end
  end

endmodule

// File: rtl/fp4_stage.sv
module fp4_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else if (en) begin
      vld_o <= vld_i;
      if (vld_i) dat_o <= dat_i;
    end
  end

endmodule

// File: rtl/fp4_round.sv
module fp4_round #(
  parameter int RW = 16
) (
  input  logic [31:0]   f_in,
  input  logic          stoch,
  input  logic [RW-1:0] rnd,
  output logic [3:0]    code
);
  import fp4_pkg::*;

  // Fraction window below the grid LSB; wide enough that shifts under
  // SHIFT_LIM never drop a set bit.
  localparam int FW        = 71;
  localparam int WW        = FW + 1;
  localparam int SHIFT_LIM = WW - 24;

  logic          sgn;
  logic [7:0]    ex;
  logic [22:0]   mn;
  logic          nan_in, big, norm, above, tie, up;
  logic [7:0]    rsh;
  logic [WW-1:0] wide;
  logic [2:0]    q, qr, ek;
  logic [FW-1:0] frac;
  logic [RW:0]   sum;

  always_comb begin
    sgn    = f_in[31];
    ex     = f_in[30:23];
    mn     = f_in[22:0];
    nan_in = (ex == 8'hFF) && (mn != '0);
    big    = ex >= 8'd130;
    norm   = ex >= 8'd127;
    rsh    = 8'd126 - ex;
    wide   = '0;
    q      = '0;
    frac   = '0;
    ek     = '0;
    if (norm) begin
      // |x| >= 1: grid step is 2^(ek-1); the integer part is {1, m22}.
      ek   = 3'(ex - 8'd127);
      q    = {1'b0, 1'b1, mn[22]};
      frac = {mn[21:0], {(FW-22){1'b0}}};
    end else if (ex != 8'd0 && rsh < 8'(SHIFT_LIM)) begin
      // |x| < 1: grid step is 0.5, so scale by two and align.
      wide = {1'b1, mn, {(WW-24){1'b0}}} >> rsh;
      q    = {2'b00, wide[WW-1]};
      frac = wide[FW-1:0];
    end
    above = frac[FW-1] && (|frac[FW-2:0]);
    tie   = frac[FW-1] && !(|frac[FW-2:0]);
    sum   = {1'b0, frac[FW-1 -: RW]} + {1'b0, rnd};
    up    = (stoch == RND_STOCH) ? sum[RW] : (above || (tie && q[0]));
    qr    = q + {2'b00, up};

    if (nan_in)             code = FP4_POS_MAX;
    else if (big)           code = {sgn, 3'b111};
    else if (!norm)         code = {sgn, qr};
    else if (qr[2]) begin
      if (ek == 3'd2)       code = {sgn, 3'b111};
      else                  code = {sgn, ek[1:0] + 2'd2, 1'b0};
    end else                code = {sgn, ek[1:0] + 2'd1, qr[0]};
  end

endmodule

// File: rtl/fp4_quantizer.sv
module fp4_quantizer #(
  parameter int               LATENCY       = 2,
  parameter int               RND_W         = 16,
  parameter logic [RND_W-1:0] LFSR_TAPS     = 16'hB400,
  parameter logic [RND_W-1:0] LFSR_FALLBACK = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RND_W-1:0] lfsr_seed,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_stoch,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_code
);

  localparam int AW = 32 + 1 + RND_W;

  logic             adv, acc;
  logic [RND_W-1:0] rnd_q;
  logic             q_valid;
  logic [31:0]      q_f32;
  logic             q_stoch;
  logic [RND_W-1:0] q_rnd;
  logic [3:0]       q_code;

  // All stages move together; a held output freezes the pipe.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign acc      = in_valid && adv;

  fp4_lfsr #(.W(RND_W), .TAPS(LFSR_TAPS), .FALLBACK(LFSR_FALLBACK)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (lfsr_seed),
    .step  (acc),
    .state (rnd_q)
  );

  generate
    if (LATENCY == 1) begin : g_lat1
      assign q_valid = in_valid;
      assign q_f32   = in_data;
      assign q_stoch = in_stoch;
      assign q_rnd   = rnd_q;
    end else begin : g_lat2
      logic [AW-1:0] a_dat;
      fp4_stage #(.W(AW)) u_stage_a (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv),
        .vld_i (in_valid),
        .dat_i ({in_data, in_stoch, rnd_q}),
        .vld_o (q_valid),
        .dat_o (a_dat)
      );
      assign {q_f32, q_stoch, q_rnd} = a_dat;
    end
  endgenerate

  fp4_round #(.RW(RND_W)) u_round (
    .f_in  (q_f32),
    .stoch (q_stoch),
    .rnd   (q_rnd),
    .code  (q_code)
  );

  fp4_stage #(.W(4)) u_stage_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .vld_i (q_valid),
    .dat_i (q_code),
    .vld_o (out_valid),
    .dat_o (out_code)
  );

endmodule

// File: rtl/fp4_quantizer_chk.sv
module fp4_quantizer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [3:0]  out_code,
  input logic [15:0] rnd,
  input logic        q_valid,
  input logic [31:0] q_in,
  input logic [3:0]  q_code
);

  logic q_nan;
  assign q_nan = (q_in[30:23] == 8'hFF) && (q_in[22:0] != 23'd0);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(rnd));

  // R7
  lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> rnd != $past(rnd));

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != 16'h0000);

  // R4
  nan_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_nan |-> q_code == 4'b0111);

  // R3
  sat_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_nan && q_in[30:23] >= 8'd130 |-> q_code[2:0] == 3'b111);

  // R5
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_nan |-> q_code[3] == q_in[31]);

endmodule

bind fp4_quantizer fp4_quantizer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .rnd       (rnd_q),
  .q_valid   (q_valid),
  .q_in      (q_f32),
  .q_code    (q_code)
);

// File: tb/fp4_quantizer_tb_top.sv
`timescale 1ns/1ps
module fp4_quantizer_tb_top;

  localparam int LAT = 2;
  localparam int NV  = 39;
  localparam int NS  = 400;
  localparam int NR  = 32;

  // {requirement, input, mode, expected code}
  localparam logic [40:0] VECS [NV] = '{
    {4'd5,  32'h00000000, 1'b0, 4'h0},   // R5 +0
    {4'd5,  32'h80000000, 1'b0, 4'h8},   // R5 -0
    {4'd5,  32'h00000001, 1'b0, 4'h0},   // R5 tiny
    {4'd5,  32'h80000001, 1'b0, 4'h8},   // R5 -tiny
    {4'd1,  32'h3F000000, 1'b0, 4'h1},   // R1 0.5
    {4'd1,  32'h3F800000, 1'b0, 4'h2},   // R1 1
    {4'd1,  32'h3FC00000, 1'b0, 4'h3},   // R1 1.5
    {4'd1,  32'h40000000, 1'b0, 4'h4},   // R1 2
    {4'd1,  32'h40400000, 1'b0, 4'h5},   // R1 3
    {4'd1,  32'h40800000, 1'b0, 4'h6},   // R1 4
    {4'd1,  32'h40C00000, 1'b0, 4'h7},   // R1 6
    {4'd1,  32'hBFC00000, 1'b0, 4'hB},   // R1 -1.5
    {4'd1,  32'hC0400000, 1'b0, 4'hD},   // R1 -3
    {4'd1,  32'hC0C00000, 1'b0, 4'hF},   // R1 -6
    {4'd2,  32'h3E800000, 1'b0, 4'h0},   // R2 0.25 tie
    {4'd2,  32'h3E99999A, 1'b0, 4'h1},   // R2 0.3
    {4'd2,  32'h3F400000, 1'b0, 4'h2},   // R2 0.75 tie
    {4'd2,  32'h3FA00000, 1'b0, 4'h2},   // R2 1.25 tie
    {4'd2,  32'h3FE00000, 1'b0, 4'h4},   // R2 1.75 tie, carry
    {4'd2,  32'h40200000, 1'b0, 4'h4},   // R2 2.5 tie
    {4'd2,  32'h40600000, 1'b0, 4'h6},   // R2 3.5 tie, carry
    {4'd2,  32'h40A00000, 1'b0, 4'h6},   // R2 5 tie
    {4'd2,  32'h40B00000, 1'b0, 4'h7},   // R2 5.5
    {4'd2,  32'h3F8CCCCD, 1'b0, 4'h2},   // R2 1.1
    {4'd2,  32'h4039999A, 1'b0, 4'h5},   // R2 2.9
    {4'd2,  32'hBF400000, 1'b0, 4'hA},   // R2 -0.75
    {4'd3,  32'h40E00000, 1'b0, 4'h7},   // R3 7 tie
    {4'd3,  32'h42C80000, 1'b0, 4'h7},   // R3 100
    {4'd3,  32'hC2C80000, 1'b0, 4'hF},   // R3 -100
    {4'd3,  32'h7F800000, 1'b0, 4'h7},   // R3 +inf
    {4'd3,  32'hFF800000, 1'b0, 4'hF},   // R3 -inf
    {4'd3,  32'h7F7FFFFF, 1'b1, 4'h7},   // R3 max float, stochastic
    {4'd4,  32'h7FC00000, 1'b0, 4'h7},   // R4 qNaN
    {4'd4,  32'hFFC00000, 1'b0, 4'h7},   // R4 negative NaN
    {4'd4,  32'h7F800001, 1'b1, 4'h7},   // R4 sNaN stochastic
    {4'd6,  32'h40400000, 1'b1, 4'h5},   // R6 exact 3
    {4'd6,  32'h80000000, 1'b1, 4'h8},   // R6 exact -0
    {4'd6,  32'h3F000000, 1'b1, 4'h1},   // R6 exact 0.5
    {4'd6,  32'hC0800000, 1'b1, 4'hE}    // R6 exact -4
  };

  localparam logic [31:0] MAGS [8] = '{
    32'h00000000, 32'h3F000000, 32'h3F800000, 32'h3FC00000,
    32'h40000000, 32'h40400000, 32'h40800000, 32'h40C00000
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lfsr_seed = 16'h1234;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_stoch = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp4_quantizer #(.LATENCY(LAT)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lfsr_seed (lfsr_seed),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_stoch  (in_stoch),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] seed);
    @(negedge clk);
    rst_n = 1'b0;
    lfsr_seed = seed;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a negedge with an empty pipe and out_ready high.
  task automatic xfer(input logic [31:0] d, input logic st, output logic [3:0] c,
                      output int lat);
    in_valid = 1'b1;
    in_data  = d;
    in_stoch = st;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    c = out_code;
    @(negedge clk);
  endtask

  logic [3:0] seq_a [NR];
  logic [3:0] seq_b [NR];

  initial begin
    logic [3:0] c;
    int lat;
    int ups;
    bit inset;

    do_reset(16'h1234);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid after reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R10 in_ready after reset", 32'(in_ready), 1);

    // R11 decode helper
    for (int k = 0; k < 16; k++) begin
      logic [31:0] e;
      e = {k[3], 31'd0} | MAGS[k[2:0]];
      check(fp4_pkg::fp4_decode(4'(k)) == e, "R11 decode", fp4_pkg::fp4_decode(4'(k)), e);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i][36:5], VECS[i][4], c, lat);
      check(c == VECS[i][3:0], $sformatf("R%0d vector %0d in=%h", VECS[i][40:37], i,
            VECS[i][36:5]), 32'(c), 32'(VECS[i][3:0]));
    end

    // R8 latency
    xfer(32'h40000000, 1'b0, c, lat);
    check(lat == LAT, "R8 latency", 32'(lat), 32'(LAT));

    // R6 stochastic rate at 0.75 (p = 1/2), neighbours 0.5 / 1.0
    ups = 0; inset = 1'b1;
    for (int i = 0; i < NS; i++) begin
      xfer(32'h3F400000, 1'b1, c, lat);
      if (c == 4'h2) ups++;
      else if (c != 4'h1) inset = 1'b0;
    end
    check(inset, "R6 0.75 neighbours", 0, 1);
    check(ups > 150 && ups < 250, "R6 0.75 up count", 32'(ups), 200);

    // R6 stochastic rate at 2.25 (p = 1/4), neighbours 2 / 3
    ups = 0; inset = 1'b1;
    for (int i = 0; i < NS; i++) begin
      xfer(32'h40100000, 1'b1, c, lat);
      if (c == 4'h5) ups++;
      else if (c != 4'h4) inset = 1'b0;
    end
    check(inset, "R6 2.25 neighbours", 0, 1);
    check(ups > 60 && ups < 140, "R6 2.25 up count", 32'(ups), 100);

    // R7 replay with idle gaps gives the same sequence
    do_reset(16'h1234);
    for (int i = 0; i < NR; i++) begin
      xfer(32'h3F400000, 1'b1, c, lat);
      seq_a[i] = c;
    end
    do_reset(16'h1234);
    for (int i = 0; i < NR; i++) begin
      repeat (i % 3) @(negedge clk);
      xfer(32'h3F400000, 1'b1, c, lat);
      seq_b[i] = c;
    end
    ups = 0;
    for (int i = 0; i < NR; i++) if (seq_a[i] != seq_b[i]) ups++;
    check(ups == 0, "R7 replay with gaps", 32'(ups), 0);

    // R7 zero seed equals fallback seed
    do_reset(16'h0000);
    for (int i = 0; i < NR; i++) begin
      xfer(32'h3F400000, 1'b1, c, lat);
      seq_a[i] = c;
    end
    do_reset(16'hACE1);
    for (int i = 0; i < NR; i++) begin
      xfer(32'h3F400000, 1'b1, c, lat);
      seq_b[i] = c;
    end
    ups = 0;
    for (int i = 0; i < NR; i++) if (seq_a[i] != seq_b[i]) ups++;
    check(ups == 0, "R7 zero seed fallback", 32'(ups), 0);

    // R9 back-pressure and R8 ordering
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 32'h40C00000; in_stoch = 1'b0;
    check(in_ready == 1'b1, "R9 ready when empty", 32'(in_ready), 1);
    @(negedge clk);
    in_data = 32'hBFC00000;
    check(in_ready == 1'b1, "R9 ready with output empty", 32'(in_ready), 1);
    @(negedge clk);
    in_data = 32'h3F000000;
    check(out_valid && out_code == 4'h7, "R9 first result held", 32'(out_code), 32'h7);
    check(in_ready == 1'b0, "R9 ready low under stall", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(out_valid && out_code == 4'h7, "R9 code stable under stall", 32'(out_code), 32'h7);
    check(in_ready == 1'b0, "R9 ready still low", 32'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_code == 4'hB, "R8 second in order", 32'(out_code), 32'hB);
    @(negedge clk);
    check(out_valid && out_code == 4'h1, "R8 third in order", 32'(out_code), 32'h1);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 pipe drains", 32'(out_valid), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule